// File: doc/BRIEF.md
# Two-Bank Dual-Request Memory with Conflict Replay

This block is a synchronous memory split into two banks. It takes up to two read or write requests per cycle, one on each request port. When the two requests fall in different banks, both banks are accessed in the same cycle. Seen from outside, the memory then behaves like a two-ported array. When both requests fall in the same bank, port 0 is served. The port 1 request is parked in a four-entry replay queue and reissued once its bank is free.

A parameter picks how addresses are spread over the banks:
- Split by the top address bit, so each bank holds one contiguous half.
- Split by the bottom address bit, so even and odd addresses alternate between the banks.

Each bank has its own response channel. A response appears one cycle after the bank access and carries the originating port, the request tag and a write flag. A per-bank enable output shows which banks are active in the current cycle.

Top module: `dual_bank_mem`

## Requirements
- R1: With MAP = MAP_HIGH the bank is address bit AW-1 and the row is the remaining low bits. With MAP = MAP_LOW the bank is address bit 0 and the row is bits AW-1..1. Each response is returned on the channel of its request's bank.
- R2: A request served in a cycle produces a response on its bank's channel in the next cycle. A read returns the last value written to that address.
- R3: If both ports present requests to different banks while the replay queue is empty, both are accepted together. Both response channels are valid in the following cycle.
- R4: If both ports target the same bank, port 0 is served and the port 1 request is queued. The queued request is served in a later cycle, and every accepted request eventually gets a response.
- R5: Each response channel carries rsp_port (0 = port 0, 1 = port 1), the request's tag and rsp_we (1 = write). Channel b uses bit b of the valid, port and write vectors and slice b of the tag and data vectors.
- R6: bank_en bit b is high in exactly the cycles in which bank b is accessed. A bank that no request addresses stays disabled.
- R7: req0_ready is always 1. req1_ready is 0 while the replay queue holds four entries.
- R8: While the replay queue is not empty, newly accepted port 1 requests join its tail. Port 1 responses come back in the order the port 1 requests were accepted.
- R9: A read that follows a write to the same address from the same port returns the written data, including when either request passed through the replay queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0_valid | input | 1 | Port 0 request present |
| req0_ready | output | 1 | Port 0 may issue (always 1) |
| req0_we | input | 1 | Port 0 write (1) or read (0) |
| req0_addr | input | AW | Port 0 address |
| req0_wdata | input | DW | Port 0 write data |
| req0_tag | input | TW | Port 0 request tag |
| req1_valid | input | 1 | Port 1 request present |
| req1_ready | output | 1 | Port 1 may issue (replay queue not full) |
| req1_we | input | 1 | Port 1 write (1) or read (0) |
| req1_addr | input | AW | Port 1 address |
| req1_wdata | input | DW | Port 1 write data |
| req1_tag | input | TW | Port 1 request tag |
| bank_en | output | 2 | Per-bank access enable in the current cycle |
| rsp_valid | output | 2 | Per-bank response valid |
| rsp_port | output | 2 | Per-bank originating port |
| rsp_we | output | 2 | Per-bank response is for a write |
| rsp_tag | output | 2*TW | Per-bank response tag |
| rsp_rdata | output | 2*DW | Per-bank read data |

## Verification
Directed patterns come first, each aimed at one behaviour:
- A split-bank pair that must be served together, against a same-bank pair that must serialise.
- A write then read through the replay path.
- A burst that holds port 0 on one bank until port 1 backs up and its ready falls.

A long sweep then runs both mapping variants side by side on identical stimulus. One address that is a conflict under high-order mapping is often a split under low-order mapping, so the two instances tell the mappings apart. Write/read pairs to the same address in every sweep step separate correct in-order replay from stale or reordered data. A per-port expectation queue with an arithmetic memory model flags any response that arrives out of order, on the wrong bank channel, or never.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  typedef enum logic {
    MAP_HIGH = 1'b0,
    MAP_LOW  = 1'b1
  } map_e;

  localparam int NB = 2;
endpackage

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int RW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int ROWS = 1 << RW;

  logic [DW-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[row] <= wdata;
      else    rdata      <= cells[row];
    end
  end
endmodule

// File: rtl/dbm_replay_q.sv
module dbm_replay_q #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = slots[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/dbm_route.sv
module dbm_route import dbm_pkg::*; #(
  parameter int   AW  = 6,
  parameter map_e MAP = MAP_HIGH
) (
  input  logic          p0_v,
  input  logic [AW-1:0] p0_addr,
  input  logic          c_v,
  input  logic [AW-1:0] c_addr,
  output logic          p0_bank,
  output logic          c_bank,
  output logic [AW-2:0] p0_row,
  output logic [AW-2:0] c_row,
  output logic          c_go,
  output logic [NB-1:0] bank_en,
  output logic [NB-1:0] src_p1
);
  generate
    if (MAP == MAP_LOW) begin : g_low
      assign p0_bank = p0_addr[0];
      assign c_bank  = c_addr[0];
      assign p0_row  = p0_addr[AW-1:1];
      assign c_row   = c_addr[AW-1:1];
    end else begin : g_high
      assign p0_bank = p0_addr[AW-1];
      assign c_bank  = c_addr[AW-1];
      assign p0_row  = p0_addr[AW-2:0];
      assign c_row   = c_addr[AW-2:0];
    end
  endgenerate

  assign c_go = c_v && !(p0_v && (c_bank == p0_bank));

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      src_p1[b]  = c_go && (c_bank == 1'(b));
      bank_en[b] = (p0_v && (p0_bank == 1'(b))) || src_p1[b];
    end
  end
endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem import dbm_pkg::*; #(
  parameter int   AW     = 6,
  parameter int   DW     = 16,
  parameter int   TW     = 4,
  parameter int   QDEPTH = 4,
  parameter map_e MAP    = MAP_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req0_valid,
  output logic             req0_ready,
  input  logic             req0_we,
  input  logic [AW-1:0]    req0_addr,
  input  logic [DW-1:0]    req0_wdata,
  input  logic [TW-1:0]    req0_tag,
  input  logic             req1_valid,
  output logic             req1_ready,
  input  logic             req1_we,
  input  logic [AW-1:0]    req1_addr,
  input  logic [DW-1:0]    req1_wdata,
  input  logic [TW-1:0]    req1_tag,
  output logic [NB-1:0]    bank_en,
  output logic [NB-1:0]    rsp_valid,
  output logic [NB-1:0]    rsp_port,
  output logic [NB-1:0]    rsp_we,
  output logic [NB*TW-1:0] rsp_tag,
  output logic [NB*DW-1:0] rsp_rdata
);
  localparam int RW    = AW - 1;
  localparam int ENT_W = 1 + AW + DW + TW;

  logic [ENT_W-1:0] q_din, q_dout;
  logic             q_push, q_pop, q_empty, q_full;

  logic          c_v, c_we;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic [TW-1:0] c_tag;

  logic          p0_bank, c_bank, c_go;
  logic [RW-1:0] p0_row, c_row;
  logic [NB-1:0] src_p1;

  assign q_din = {req1_we, req1_addr, req1_wdata, req1_tag};

  // Port 1 candidate: queue head first, else a fresh request
  always_comb begin
    if (!q_empty) begin
      {c_we, c_addr, c_wdata, c_tag} = q_dout;
      c_v = 1'b1;
    end else begin
      {c_we, c_addr, c_wdata, c_tag} = q_din;
      c_v = req1_valid;
    end
  end

  assign req0_ready = 1'b1;
  assign req1_ready = !q_full;
  assign q_push     = req1_valid && !q_full && (!q_empty || !c_go);
  assign q_pop      = !q_empty && c_go;

  dbm_replay_q #(.W(ENT_W), .DEPTH(QDEPTH)) replay_i (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  dbm_route #(.AW(AW), .MAP(MAP)) route_i (
    .p0_v    (req0_valid),
    .p0_addr (req0_addr),
    .c_v     (c_v),
    .c_addr  (c_addr),
    .p0_bank (p0_bank),
    .c_bank  (c_bank),
    .p0_row  (p0_row),
    .c_row   (c_row),
    .c_go    (c_go),
    .bank_en (bank_en),
    .src_p1  (src_p1)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic          b_we;
      logic [RW-1:0] b_row;
      logic [DW-1:0] b_wdata;
      logic [TW-1:0] b_tag;

      assign b_we    = src_p1[b] ? c_we    : req0_we;
      assign b_row   = src_p1[b] ? c_row   : p0_row;
      assign b_wdata = src_p1[b] ? c_wdata : req0_wdata;
      assign b_tag   = src_p1[b] ? c_tag   : req0_tag;

      dbm_bank #(.RW(RW), .DW(DW)) array_i (
        .clk   (clk),
        .en    (bank_en[b]),
        .we    (b_we),
        .row   (b_row),
        .wdata (b_wdata),
        .rdata (rsp_rdata[b*DW +: DW])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          rsp_valid[b]          <= 1'b0;
          rsp_port[b]           <= 1'b0;
          rsp_we[b]             <= 1'b0;
          rsp_tag[b*TW +: TW]   <= '0;
        end else begin
          rsp_valid[b]          <= bank_en[b];
          rsp_port[b]           <= src_p1[b];
          rsp_we[b]             <= b_we;
          rsp_tag[b*TW +: TW]   <= b_tag;
        end
      end
    end
  endgenerate

  // R3
  dual_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && req1_valid && q_empty && (p0_bank != c_bank)) |=> (rsp_valid == 2'b11));
  // R4
  conflict_park_chk: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && req1_valid && q_empty && (p0_bank == c_bank)) |=> !q_empty);
  // R5
  p0_bank0_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && !p0_bank) |=> (rsp_valid[0] && !rsp_port[0] && rsp_tag[TW-1:0] == $past(req0_tag)));
  // R5
  p0_bank1_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && p0_bank) |=> (rsp_valid[1] && !rsp_port[1] && rsp_tag[2*TW-1:TW] == $past(req0_tag)));
endmodule

// File: tb/dual_bank_mem_tb.sv
module dual_bank_mem_tb_top;
  import dbm_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        v0 = 0, we0 = 0, v1 = 0, we1 = 0;
  logic [5:0]  a0 = 0, a1 = 0;
  logic [15:0] d0 = 0, d1 = 0;
  logic [3:0]  t0 = 0, t1 = 0;

  logic        r0_h, r1_h, r0_l, r1_l;
  logic [1:0]  be_h, rv_h, rp_h, rw_h, be_l, rv_l, rp_l, rw_l;
  logic [7:0]  rt_h, rt_l;
  logic [31:0] rd_h, rd_l;

  dual_bank_mem #(.MAP(MAP_HIGH)) dut_i (
    .clk(clk), .rst(rst),
    .req0_valid(v0), .req0_ready(r0_h), .req0_we(we0), .req0_addr(a0), .req0_wdata(d0), .req0_tag(t0),
    .req1_valid(v1), .req1_ready(r1_h), .req1_we(we1), .req1_addr(a1), .req1_wdata(d1), .req1_tag(t1),
    .bank_en(be_h), .rsp_valid(rv_h), .rsp_port(rp_h), .rsp_we(rw_h), .rsp_tag(rt_h), .rsp_rdata(rd_h));

  dual_bank_mem #(.MAP(MAP_LOW)) dut_lo_i (
    .clk(clk), .rst(rst),
    .req0_valid(v0), .req0_ready(r0_l), .req0_we(we0), .req0_addr(a0), .req0_wdata(d0), .req0_tag(t0),
    .req1_valid(v1), .req1_ready(r1_l), .req1_we(we1), .req1_addr(a1), .req1_wdata(d1), .req1_tag(t1),
    .bank_en(be_l), .rsp_valid(rv_l), .rsp_port(rp_l), .rsp_we(rw_l), .rsp_tag(rt_l), .rsp_rdata(rd_l));

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [3:0] tg = 0;

  // scoreboard: [dut][port][entry]
  logic [3:0]  sb_tag   [0:1][0:1][0:1023];
  logic        sb_we    [0:1][0:1][0:1023];
  logic        sb_bank  [0:1][0:1][0:1023];
  logic        sb_known [0:1][0:1][0:1023];
  logic [15:0] sb_data  [0:1][0:1][0:1023];
  int          sb_hd    [0:1][0:1];
  int          sb_tl    [0:1][0:1];
  logic [15:0] mdl      [0:1][0:63];
  bit          mknown   [0:1][0:63];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic rec(input int d, input int p, input logic we, input logic [5:0] ad,
                     input logic [15:0] dt, input logic [3:0] tag);
    int i;
    i = sb_tl[d][p] % 1024;
    sb_tag[d][p][i]  = tag;
    sb_we[d][p][i]   = we;
    sb_bank[d][p][i] = (d == 1) ? ad[0] : ad[5];
    if (we) begin
      mdl[d][ad]    = dt;
      mknown[d][ad] = 1;
    end
    sb_data[d][p][i]  = mdl[d][ad];
    sb_known[d][p][i] = mknown[d][ad];
    sb_tl[d][p]++;
  endtask

  task automatic check_rsp(input int d, input int b, input logic port, input logic we,
                           input logic [3:0] tag, input logic [15:0] rdata);
    int p, i;
    p = int'(port);
    if (sb_hd[d][p] == sb_tl[d][p]) begin
      chk(0, $sformatf("R4 dut%0d unexpected rsp port%0d", d, p), tag, 0);
      return;
    end
    i = sb_hd[d][p] % 1024;
    sb_hd[d][p]++;
    chk(tag == sb_tag[d][p][i], $sformatf("R8 R5 dut%0d port%0d tag order", d, p), tag, sb_tag[d][p][i]);
    chk(we == sb_we[d][p][i], $sformatf("R5 dut%0d port%0d we flag", d, p), we, sb_we[d][p][i]);
    chk(1'(b) == sb_bank[d][p][i], $sformatf("R1 dut%0d port%0d bank channel", d, p), b, sb_bank[d][p][i]);
    if (!we && sb_known[d][p][i])
      chk(rdata == sb_data[d][p][i], $sformatf("R2 R9 dut%0d port%0d read data", d, p), rdata, sb_data[d][p][i]);
  endtask

  // Monitor: responses first, then record the requests taken at the coming edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rv_h[0]) check_rsp(0, 0, rp_h[0], rw_h[0], rt_h[3:0], rd_h[15:0]);
      if (rv_h[1]) check_rsp(0, 1, rp_h[1], rw_h[1], rt_h[7:4], rd_h[31:16]);
      if (rv_l[0]) check_rsp(1, 0, rp_l[0], rw_l[0], rt_l[3:0], rd_l[15:0]);
      if (rv_l[1]) check_rsp(1, 1, rp_l[1], rw_l[1], rt_l[7:4], rd_l[31:16]);
      if (v0 && r0_h) rec(0, 0, we0, a0, d0, t0);
      if (v1 && r1_h) rec(0, 1, we1, a1, d1, t1);
      if (v0 && r0_l) rec(1, 0, we0, a0, d0, t0);
      if (v1 && r1_l) rec(1, 1, we1, a1, d1, t1);
    end
  end

  task automatic step(input bit iv0, input bit iw0, input logic [5:0] ia0, input logic [15:0] id0,
                      input bit iv1, input bit iw1, input logic [5:0] ia1, input logic [15:0] id1);
    @(posedge clk);
    #1;
    v0 = iv0; we0 = iw0; a0 = ia0; d0 = id0; t0 = tg; tg = tg + 1'b1;
    v1 = iv1; we1 = iw1; a1 = ia1; d1 = id1; t1 = tg; tg = tg + 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 6'd0, 16'd0, 0, 0, 6'd0, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++) begin
        sb_hd[d][p] = 0;
        sb_tl[d][p] = 0;
      end
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 64; a++) begin
        mdl[d][a] = '0;
        mknown[d][a] = 0;
      end

    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(r1_h == 1'b1 && r0_h == 1'b1, "R7 ready after reset", {r0_h, r1_h}, 2'b11);
    chk(rv_h == 2'b00 && rv_l == 2'b00, "R2 no response after reset", {rv_h, rv_l}, 0);
    chk(be_h == 2'b00, "R6 banks idle after reset", be_h, 0);

    // Split banks (high map): 0 -> bank0, 34 -> bank1
    step(1, 1, 6'd0, 16'h1111, 1, 1, 6'd34, 16'h2222);
    chk(be_h == 2'b11, "R3 R6 both banks enabled", be_h, 2'b11);
    chk(be_l == 2'b01, "R1 low map both in bank0", be_l, 2'b01);
    idle();
    chk(rv_h == 2'b11, "R3 both responses next cycle", rv_h, 2'b11);
    chk(rp_h == 2'b10, "R5 port ids per channel", rp_h, 2'b10);

    // Same bank conflict: 0 and 2 both bank0 (high map)
    step(1, 0, 6'd0, 16'd0, 1, 0, 6'd2, 16'd0);
    chk(be_h == 2'b01, "R6 only bank0 on conflict", be_h, 2'b01);
    idle();
    chk(rv_h == 2'b01 && rp_h[0] == 1'b0, "R4 port0 wins conflict", {rv_h, rp_h}, 4'b0100);
    chk(be_h == 2'b01, "R4 replay uses bank0", be_h, 2'b01);
    idle();
    chk(rv_h == 2'b01 && rp_h[0] == 1'b1, "R4 replayed port1 served later", {rv_h, rp_h}, 4'b0101);

    // Port 1 write then read through bank1
    step(0, 0, 6'd0, 16'd0, 1, 1, 6'd38, 16'hBEEF);
    step(0, 0, 6'd0, 16'd0, 1, 0, 6'd38, 16'd0);
    idle();
    chk(rv_h[1] && rd_h[31:16] == 16'hBEEF, "R9 port1 read after write", rd_h[31:16], 16'hBEEF);

    // Fill replay queue: port0 holds bank0, port1 keeps hitting bank0
    step(1, 0, 6'd0, 16'd0, 1, 0, 6'd2, 16'd0);
    step(1, 0, 6'd0, 16'd0, 1, 0, 6'd6, 16'd0);
    step(1, 0, 6'd0, 16'd0, 1, 0, 6'd10, 16'd0);
    step(1, 0, 6'd0, 16'd0, 1, 0, 6'd14, 16'd0);
    step(1, 0, 6'd0, 16'd0, 1, 0, 6'd18, 16'd0);
    chk(r1_h == 1'b0, "R7 port1 ready low when queue full", r1_h, 0);
    chk(r0_h == 1'b1, "R7 port0 ready stays high", r0_h, 1);
    chk(be_h == 2'b01, "R6 bank1 idle while blocked", be_h, 2'b01);
    repeat (8) idle();

    // Sweep: paired write/read per address on each port, port0 bit1=0, port1 bit1=1
    for (int c = 0; c < 1200; c++) begin
      logic [5:0] pa0, pa1;
      pa0 = 6'((c >> 1) * 13) & 6'b111101;
      pa1 = 6'((c >> 1) * 11 + 5) | 6'b000010;
      step((c % 7) != 6, (c % 2) == 0, pa0, 16'(c * 37 + 1),
           (c % 5) != 4, (c % 2) == 0, pa1, 16'(c * 53 + 7));
    end
    repeat (12) idle();

    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++)
        chk(sb_hd[d][p] == sb_tl[d][p], $sformatf("R4 dut%0d port%0d all requests answered", d, p),
            sb_tl[d][p] - sb_hd[d][p], 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule